// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block keeps the transmit and receive error counts of a CAN node and works out from them which fault-confinement state the node is in. The protocol engine sends it single-cycle pulses: transmit error, receive error, transmit success, receive success, and bus-off recovery complete. The block updates both counts on each clock edge and shows the node as error-active, error-passive or bus-off.

A host sees the two counts through a small read port. In normal operation the host cannot change them. The one exception is a test path. While the node is halted and the 3-bit test field selects the error-counter write code, a host write loads one value into both counters at once. A reset request clears the counts, and so does entering bus-off.

Top module: `can_err_confine`

## Requirements
- R1: A reset request clears both counters to zero and returns the node to error-active on the next clock edge. It overrides every other input in that cycle, including a test write.
- R2: A transmit error adds 8 to the transmit counter. A transmit success subtracts 1 unless the counter is already zero. If both pulses arrive in the same cycle, the error wins.
- R3: A receive error adds 1 to the receive counter. A receive success has three outcomes. A value above 127 becomes 119. A value from 1 to 127 drops by 1. Zero stays at zero. If both pulses arrive in the same cycle, the error wins.
- R4: Both counters saturate at 16'hFFFF and never wrap past it.
- R5: Exactly one of the three state flags is high at any time. When not bus-off, the node is error-passive if either counter is above 127, and error-active otherwise.
- R6: A transmit error that would take the transmit counter above 255 puts the node in bus-off and clears both counters on that same edge.
- R7: While the node is bus-off, both counters stay at zero and all counting events are ignored. A recovery-complete pulse returns the node to error-active. A recovery-complete pulse outside bus-off has no effect.
- R8: A write with the halt input high and the test field equal to 3'b100 loads the written value into both counters. It takes priority over counting events in the same cycle, and it never changes the bus-off flag by itself.
- R9: A write made while not halted, or with any other test-field value, or while bus-off, leaves both counters unchanged.
- R10: The read port returns the transmit counter when rd_sel is 0 and the receive counter when rd_sel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err | input | 1 | Transmit error pulse |
| tx_ok | input | 1 | Successful transmit pulse |
| rx_err | input | 1 | Receive error pulse |
| rx_ok | input | 1 | Successful receive pulse |
| recov_done | input | 1 | Bus-off recovery complete pulse |
| reset_req | input | 1 | Synchronous counter reset request |
| halted | input | 1 | Node is in halt mode |
| test_sel | input | 3 | Test-mode field; 3'b100 enables counter writes |
| wr_en | input | 1 | Host write strobe for the counters |
| wr_data | input | 16 | Host write value, loaded into both counters |
| rd_sel | input | 1 | Read select: 0 transmit counter, 1 receive counter |
| rd_data | output | 16 | Selected counter value |
| tx_cnt | output | 16 | Transmit error counter |
| rx_cnt | output | 16 | Receive error counter |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |

## Verification
The bench targets the 127/128 passive threshold, in both directions. A design that compares with the wrong operator shows the wrong flag at exactly one count. It also targets the 255/256 bus-off threshold, reached from 247 and from 248. A design that is off by one there either leaves 255 bus-off or fails to go bus-off at 256.

The bench also covers the receive reload from above 127 to 119 and saturation at 16'hFFFF. Getting either wrong gives a wrapped small value or a plain decrement. Priority collisions get their own checks: write against event, reset against write, and error against success. So do writes that should be ignored: not halted, the wrong test code, or during bus-off. In each case a wrong ordering or a missing qualifier leaves a visible change in the counters.

// File: rtl/can_err_confine.sv
module can_err_confine #(
  parameter int CNT_W       = 16,
  parameter int TX_STEP     = 8,
  parameter int PASSIVE_LIM = 127,
  parameter int BOFF_LIM    = 255,
  parameter int RX_RELOAD   = 119,
  parameter logic [2:0] WR_TEST_CODE = 3'b100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             recov_done,
  input  logic             reset_req,
  input  logic             halted,
  input  logic [2:0]       test_sel,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] tx_cnt,
  output logic [CNT_W-1:0] rx_cnt,
  output logic             err_active,
  output logic             err_passive,
  output logic             bus_off
);

  localparam logic [CNT_W-1:0] CMAX   = '1;
  localparam logic [CNT_W-1:0] PAS_T  = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] BOFF_T = CNT_W'(BOFF_LIM);
  localparam logic [CNT_W-1:0] RLD_V  = CNT_W'(RX_RELOAD);
  localparam logic [CNT_W:0]   STEP_V = (CNT_W+1)'(TX_STEP);

  logic [CNT_W-1:0] tec, rec;
  logic             boff;

  logic [CNT_W:0]   tec_sum;
  logic [CNT_W-1:0] tec_nxt, rec_nxt;
  logic             test_wr, enter_boff, passive_raw;

  assign test_wr = wr_en && halted && (test_sel == WR_TEST_CODE);
  assign tec_sum = {1'b0, tec} + STEP_V;

  always_comb begin
    tec_nxt = tec;
    if (tx_err)
      tec_nxt = tec_sum[CNT_W] ? CMAX : tec_sum[CNT_W-1:0];
    else if (tx_ok && tec != '0)
      tec_nxt = tec - 1'b1;
  end

  always_comb begin
    rec_nxt = rec;
    if (rx_err) begin
      if (rec != CMAX) rec_nxt = rec + 1'b1;
    end else if (rx_ok) begin
      if (rec > PAS_T)      rec_nxt = RLD_V;
      else if (rec != '0)   rec_nxt = rec - 1'b1;
    end
  end

  assign enter_boff = tx_err && (tec_nxt > BOFF_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec  <= '0;
      rec  <= '0;
      boff <= 1'b0;
    end else if (reset_req) begin
      tec  <= '0;
      rec  <= '0;
      boff <= 1'b0;
    end else if (boff) begin
      tec <= '0;
      rec <= '0;
      if (recov_done) boff <= 1'b0;
    end else if (test_wr) begin
      tec <= wr_data;
      rec <= wr_data;
    end else if (enter_boff) begin
      tec  <= '0;
      rec  <= '0;
      boff <= 1'b1;
    end else begin
      tec <= tec_nxt;
      rec <= rec_nxt;
    end
  end

  assign passive_raw = (tec > PAS_T) || (rec > PAS_T);
  assign bus_off     = boff;
  assign err_passive = !boff && passive_raw;
  assign err_active  = !boff && !passive_raw;
  assign tx_cnt      = tec;
  assign rx_cnt      = rec;
  assign rd_data     = rd_sel ? rec : tec;

  logic normal;
  assign normal = !reset_req && !boff && !test_wr;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (tx_cnt == '0 && rx_cnt == '0 && err_active));

  p_tx_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && tx_err && tec <= (BOFF_T - PAS_T - 1'b1 - 8'd0)) |=>
      (tx_cnt == $past(tec) + CNT_W'(TX_STEP)));

  p_rx_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && rx_ok && !rx_err && !enter_boff && rec > PAS_T) |=> (rx_cnt == RLD_V));

  p_rx_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && !enter_boff && rec == CMAX && !rx_ok) |=> (rx_cnt == CMAX));

  p_one_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({err_active, err_passive, bus_off}) == 1);

  p_boff_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> (tx_cnt == '0 && rx_cnt == '0));

  p_boff_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !boff && !test_wr && enter_boff) |=> bus_off);

  p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && recov_done && !reset_req) |=> err_active);

  p_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !boff && test_wr) |=>
      (tx_cnt == $past(wr_data) && rx_cnt == $past(wr_data) && !bus_off));

  p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !test_wr && !reset_req && !boff &&
     !tx_err && !tx_ok && !rx_err && !rx_ok) |=> ($stable(tx_cnt) && $stable(rx_cnt)));

endmodule

// File: tb/can_err_confine_tb.sv
module can_err_confine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0, recov_done = 0;
  logic        reset_req = 0, halted = 0, wr_en = 0, rd_sel = 0;
  logic [2:0]  test_sel = 3'b000;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, tx_cnt, rx_cnt;
  logic        err_active, err_passive, bus_off;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_err_confine u_dut (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ok(tx_ok), .rx_err(rx_err),
    .rx_ok(rx_ok), .recov_done(recov_done), .reset_req(reset_req), .halted(halted),
    .test_sel(test_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .err_active(err_active),
    .err_passive(err_passive), .bus_off(bus_off)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_all(input string r, input int t, input int rx, input logic [2:0] st);
    chk({r, " tx"}, tx_cnt, t);
    chk({r, " rx"}, rx_cnt, rx);
    chk({r, " state"}, {err_active, err_passive, bus_off}, st);
  endtask

  task automatic ev(input logic te, to, re, ro);
    tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro;
    tick();
    tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0;
  endtask

  task automatic twrite(input logic [15:0] d);
    halted = 1; test_sel = 3'b100; wr_en = 1; wr_data = d;
    tick();
    halted = 0; test_sel = 3'b000; wr_en = 0;
  endtask

  task automatic t_reset_state();
    chk_all("R1 after reset", 0, 0, 3'b100);
  endtask

  task automatic t_tx_count();
    ev(1, 0, 0, 0); ev(1, 0, 0, 0); ev(1, 0, 0, 0);
    chk_all("R2 three tx errors", 24, 0, 3'b100);
    ev(0, 1, 0, 0);
    chk_all("R2 tx success", 23, 0, 3'b100);
    ev(1, 1, 0, 0);
    chk("R2 error beats success", tx_cnt, 31);
    rd_sel = 0; #1;
    chk("R10 read tx", rd_data, 31);
    reset_req = 1; tick(); reset_req = 0;
    ev(0, 1, 0, 0);
    chk("R2 tx success at zero", tx_cnt, 0);
  endtask

  task automatic t_rx_count();
    twrite(16'd130);
    chk_all("R8 write both", 130, 130, 3'b010);
    ev(0, 0, 0, 1);
    chk_all("R3 reload to 119", 130, 119, 3'b010);
    ev(0, 1, 0, 0); ev(0, 1, 0, 0);
    chk_all("R5 tx 128 passive", 128, 119, 3'b010);
    ev(0, 1, 0, 0);
    chk_all("R5 tx 127 active", 127, 119, 3'b100);
    rd_sel = 1; #1;
    chk("R10 read rx", rd_data, 119);
    rd_sel = 0;
    twrite(16'd1);
    ev(0, 0, 0, 1);
    chk("R3 rx 1 to 0", rx_cnt, 0);
    ev(0, 0, 0, 1);
    chk("R3 rx stays 0", rx_cnt, 0);
    ev(0, 0, 1, 1);
    chk("R3 rx error beats success", rx_cnt, 1);
    twrite(16'd127);
    ev(0, 0, 1, 0);
    chk_all("R5 rx 128 passive", 127, 128, 3'b010);
  endtask

  task automatic t_saturate();
    twrite(16'hFFFF);
    ev(0, 0, 1, 0);
    chk("R4 rx saturates", rx_cnt, 16'hFFFF);
    chk("R4 tx untouched", tx_cnt, 16'hFFFF);
    ev(0, 0, 0, 1);
    chk("R3 reload from max", rx_cnt, 119);
  endtask

  task automatic t_write_rules();
    twrite(16'd40);
    halted = 0; test_sel = 3'b100; wr_en = 1; wr_data = 16'd77; tick();
    chk_all("R9 not halted", 40, 40, 3'b100);
    halted = 1; test_sel = 3'b101; tick();
    chk_all("R9 wrong code", 40, 40, 3'b100);
    halted = 1; test_sel = 3'b100; wr_data = 16'd50; tx_err = 1; rx_ok = 1; tick();
    tx_err = 0; rx_ok = 0;
    chk_all("R8 write beats event", 50, 50, 3'b100);
    reset_req = 1; wr_data = 16'd60; tick();
    reset_req = 0; wr_en = 0; halted = 0; test_sel = 3'b000;
    chk_all("R1 reset beats write", 0, 0, 3'b100);
  endtask

  task automatic t_bus_off();
    twrite(16'd247);
    ev(1, 0, 0, 0);
    chk_all("R6 255 not bus-off", 255, 247, 3'b010);
    twrite(16'd248);
    ev(1, 0, 0, 0);
    chk_all("R6 256 enters bus-off", 0, 0, 3'b001);
    ev(1, 0, 1, 0);
    chk_all("R7 events ignored", 0, 0, 3'b001);
    twrite(16'd90);
    chk_all("R9 write in bus-off", 0, 0, 3'b001);
    recov_done = 1; tick(); recov_done = 0;
    chk_all("R7 recovery", 0, 0, 3'b100);
    twrite(16'd300);
    chk_all("R8 write no bus-off", 300, 300, 3'b010);
    ev(1, 0, 0, 0);
    chk_all("R6 from written value", 0, 0, 3'b001);
    reset_req = 1; tick(); reset_req = 0;
    chk_all("R1 reset leaves bus-off", 0, 0, 3'b100);
    twrite(16'd20);
    recov_done = 1; tick(); recov_done = 0;
    chk_all("R7 stray recovery", 20, 20, 3'b100);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset_state();
    t_tx_count();
    t_rx_count();
    t_saturate();
    t_write_rules();
    t_bus_off();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule